// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank State Tracker

This block watches the control pins of a single-data-rate SDRAM bus from the device side. On every rising clock edge it samples the clock enable, chip select, row strobe, column strobe, write enable, the auto-precharge address bit and the bank address. It classifies the sampled pins into one command and reports that command on a one-hot output one cycle later. The data bus, the storage array and all analog behaviour are outside the block.

The block keeps an open or closed state for each bank. It also tracks the activate-to-column delay, the precharge-to-activate delay, the refresh cycle time and a pending auto-precharge for each bank. A command that breaks a state precondition or a cycle limit is refused and leaves every bank unchanged. The block then raises a one-cycle error pulse, sets a sticky error flag and reports a cause code. It can be used as a protocol monitor beside a memory model or as the front end of a memory model.

All three timing limits and the burst duration used for auto-precharge are parameters given in clock cycles. The defaults are 2 cycles for the activate-to-column delay, 3 for the precharge-to-activate delay, 9 for the refresh cycle time and 4 for the burst.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: The pins are sampled as the vector {cs_n, ras_n, cas_n, we_n}. The codes are: 0011 activate, 0101 read, 0100 write, 0010 precharge, 0000 mode register set, 0001 auto refresh (when CKE is high in both the previous and the present sample), 0111 no-operation and 0110 burst stop. The command sampled in cycle k appears on `cmd_onehot` in cycle k+1. The bit indices are: 0 deselect, 1 no-operation, 2 burst stop, 3 activate, 4 read, 5 write, 6 precharge of one bank, 7 precharge of all banks, 8 mode register set, 9 auto refresh, 10 self-refresh entry, 11 clock disabled.
- R2: When cs_n is high, the command is deselect (bit 0) whatever the other pins show. When CKE was low at the previous sample, the command is clock disabled (bit 11). Neither changes any bank state.
- R3: An accepted activate opens the addressed bank, which `bank_active[ba]` shows in the next cycle. An activate to a bank that is already open is refused with cause 1.
- R4: A precharge with a10 low closes only the addressed bank. A precharge with a10 high closes every bank. A precharge of a closed bank is accepted and changes nothing.
- R5: An activate of a bank fewer than TRP cycles after that bank was closed is refused with cause 2. An activate exactly TRP cycles after the close is accepted.
- R6: A read or write to a closed bank is refused with cause 3. A read or write fewer than TRCD cycles after the bank's activate is refused with cause 4. A read or write exactly TRCD cycles after the activate is accepted.
- R7: A read or write accepted in cycle k with a10 high closes the bank by itself at cycle k+BURST. The bank reads closed from cycle k+BURST+1, and its TRP window counts from cycle k+BURST.
- R8: Mode register set, auto refresh and self-refresh entry are refused with cause 5 while any bank is open.
- R9: After an auto refresh accepted in cycle r, any command other than deselect, no-operation or clock disabled is refused with cause 6 until cycle r+TRC, when it is accepted again.
- R10: Self-refresh entry is the auto-refresh code sampled with CKE high at the previous sample and low at this one. `sref_active` rises in the next cycle. It falls after the first cycle in which CKE is sampled high again. The TRC window of R9 then counts from that exit cycle.
- R11: A refused command changes no bank state. It gives a one-cycle `err_pulse` and sets `err_sticky`, which stays high until reset. `err_cause` shows the cause of the latest refused command and holds that value over accepted commands.
- R12: During reset, `cmd_onehot`, `bank_active`, `sref_active`, `err_pulse`, `err_sticky` and `err_cause` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| a10 | input | 1 | All-bank select on precharge; auto-precharge request on read and write |
| ba | input | 2 | Bank address |
| cmd_onehot | output | 12 | One-hot code of the command sampled in the previous cycle |
| bank_active | output | 4 | One bit per bank, high while the bank is open |
| sref_active | output | 1 | High while in self-refresh |
| err_pulse | output | 1 | High for one cycle after a refused command |
| err_sticky | output | 1 | Set by any refused command, cleared only by reset |
| err_cause | output | 3 | Cause of the latest refused command |

## Verification
A wrong open or closed bit for a bank can stay hidden until the next command to that bank. Most faults therefore show up either one cycle later in `bank_active` or, one cycle after a later command, as a refusal that should not happen or a refusal that is missing. Timing counters that are off by one show only at the exact boundary cycles. The sequence therefore tries each window one cycle before it ends and again on the cycle it ends, for the precharge, activate, auto-precharge, refresh and self-refresh exit windows. Deselect, clock-disabled and refused commands are always followed by a check of the bank mask, so that a state change that should not happen is visible in the next cycle.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  typedef enum logic [3:0] {
    CMD_DESEL  = 4'd0,
    CMD_NOP    = 4'd1,
    CMD_BSTOP  = 4'd2,
    CMD_ACT    = 4'd3,
    CMD_READ   = 4'd4,
    CMD_WRITE  = 4'd5,
    CMD_PRE    = 4'd6,
    CMD_PREALL = 4'd7,
    CMD_MRS    = 4'd8,
    CMD_AREF   = 4'd9,
    CMD_SREF   = 4'd10,
    CMD_CKOFF  = 4'd11
  } cmd_e;

  localparam int NCMD = 12;

  typedef enum logic [2:0] {
    VIO_NONE     = 3'd0,
    VIO_ACT_OPEN = 3'd1,
    VIO_TRP      = 3'd2,
    VIO_RW_IDLE  = 3'd3,
    VIO_TRCD     = 3'd4,
    VIO_NOT_IDLE = 3'd5,
    VIO_TRC      = 3'd6
  } vio_e;

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
  import sdcmd_pkg::*;
(
  input  logic cke_prev,
  input  logic cke_now,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic a10,
  output cmd_e cmd
);

  always_comb begin
    cmd = CMD_NOP;
    if (!cke_prev) begin
      cmd = CMD_CKOFF;
    end else if (cs_n) begin
      cmd = CMD_DESEL;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  cmd = CMD_NOP;
        3'b110:  cmd = CMD_BSTOP;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_READ;
        3'b100:  cmd = CMD_WRITE;
        3'b010:  cmd = a10 ? CMD_PREALL : CMD_PRE;
        3'b000:  cmd = CMD_MRS;
        3'b001:  cmd = cke_now ? CMD_AREF : CMD_SREF;
        default: cmd = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdcmd_bank.sv
module sdcmd_bank #(
  parameter int TRCD  = 2,
  parameter int TRP   = 3,
  parameter int BURST = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_go,
  input  logic rw_go,
  input  logic rw_ap,
  input  logic pre_go,
  output logic active,
  output logic trp_busy,
  output logic trcd_busy
);

  localparam int MAXV = (TRCD > TRP) ? ((TRCD > BURST) ? TRCD : BURST)
                                     : ((TRP > BURST) ? TRP : BURST);
  localparam int CW   = $clog2(MAXV + 1);

  logic          active_q, active_d;
  logic [CW-1:0] trp_q, trp_d;
  logic [CW-1:0] trcd_q, trcd_d;
  logic [CW-1:0] ap_q, ap_d;
  logic          upd;

  always_comb begin
    active_d = active_q;
    trp_d    = (trp_q  != '0) ? trp_q  - 1'b1 : '0;
    trcd_d   = (trcd_q != '0) ? trcd_q - 1'b1 : '0;
    ap_d     = (ap_q   != '0) ? ap_q   - 1'b1 : '0;
    if (pre_go) begin
      if (active_q) begin
        active_d = 1'b0;
        trp_d    = CW'(TRP - 1);
      end
      ap_d = '0;
    end else if (act_go) begin
      active_d = 1'b1;
      trcd_d   = CW'(TRCD - 1);
    end else if (rw_go) begin
      ap_d = rw_ap ? CW'(BURST) : '0;
    end else if (ap_q == CW'(1)) begin
      active_d = 1'b0;
      trp_d    = CW'(TRP - 1);
    end
  end

  assign upd = act_go | rw_go | pre_go | (trp_q != '0) | (trcd_q != '0) | (ap_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      trp_q    <= '0;
      trcd_q   <= '0;
      ap_q     <= '0;
    end else if (upd) begin
      active_q <= active_d;
      trp_q    <= trp_d;
      trcd_q   <= trcd_d;
      ap_q     <= ap_d;
    end
  end

  assign active    = active_q;
  assign trp_busy  = (trp_q != '0);
  assign trcd_busy = (trcd_q != '0);

  AST_OPEN_AFTER_TRP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> ($past(trp_q) == '0)); // R5

  AST_RW_ON_READY_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    rw_go |-> (active_q && trcd_q == '0)); // R6

  AST_AP_CLOSES_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_q == CW'(1) && !act_go && !rw_go && !pre_go) |=> !active_q); // R7

endmodule

// File: rtl/sdcmd_refresh.sv
module sdcmd_refresh #(
  parameter int TRC = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic aref_go,
  input  logic sref_go,
  input  logic cke_prev,
  input  logic cke_now,
  output logic trc_busy,
  output logic in_sref
);

  localparam int CW = $clog2(TRC + 1);

  logic [CW-1:0] trc_q, trc_d;
  logic          sref_q, sref_d;
  logic          sr_exit;
  logic          upd;

  assign sr_exit = sref_q && !cke_prev && cke_now;

  always_comb begin
    trc_d  = (trc_q != '0) ? trc_q - 1'b1 : '0;
    sref_d = sref_q;
    if (aref_go || sr_exit) trc_d = CW'(TRC - 1);
    if (sref_go)            sref_d = 1'b1;
    else if (sr_exit)       sref_d = 1'b0;
  end

  assign upd = aref_go | sref_go | sr_exit | (trc_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trc_q  <= '0;
      sref_q <= 1'b0;
    end else if (upd) begin
      trc_q  <= trc_d;
      sref_q <= sref_d;
    end
  end

  assign trc_busy = (trc_q != '0);
  assign in_sref  = sref_q;

  AST_SREF_EXIT_ON_CKE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sref_q) |-> ($past(cke_now) && !$past(cke_prev))); // R10

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdcmd_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int TRCD  = 2,
  parameter int TRP   = 3,
  parameter int TRC   = 9,
  parameter int BURST = 4,
  localparam int BAW  = $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             a10,
  input  logic [BAW-1:0]   ba,
  output logic [NCMD-1:0]  cmd_onehot,
  output logic [NBANK-1:0] bank_active,
  output logic             sref_active,
  output logic             err_pulse,
  output logic             err_sticky,
  output logic [2:0]       err_cause
);

  // reset: asserted at once, released after two edges
  logic [1:0] rsync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  logic cke_q;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cke_q <= 1'b0;
    else         cke_q <= cke;
  end

  cmd_e cmd;
  sdcmd_decode u_dec (
    .cke_prev (cke_q),
    .cke_now  (cke),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .a10      (a10),
    .cmd      (cmd)
  );

  logic [NBANK-1:0] b_active, b_trp_busy, b_trcd_busy;
  logic [NBANK-1:0] act_go, rw_go, pre_go;
  logic             trc_busy, in_sref, aref_go, sref_go;
  vio_e             vio;
  logic             ok, quiet, is_rw;

  // legality of the sampled command
  always_comb begin
    vio   = VIO_NONE;
    quiet = (cmd == CMD_DESEL) || (cmd == CMD_NOP) || (cmd == CMD_CKOFF);
    is_rw = (cmd == CMD_READ) || (cmd == CMD_WRITE);
    if (!quiet && trc_busy) begin
      vio = VIO_TRC;
    end else begin
      case (cmd)
        CMD_ACT: begin
          if (b_active[ba])        vio = VIO_ACT_OPEN;
          else if (b_trp_busy[ba]) vio = VIO_TRP;
        end
        CMD_READ, CMD_WRITE: begin
          if (!b_active[ba])        vio = VIO_RW_IDLE;
          else if (b_trcd_busy[ba]) vio = VIO_TRCD;
        end
        CMD_MRS, CMD_AREF, CMD_SREF: begin
          if (|b_active) vio = VIO_NOT_IDLE;
        end
        default: vio = VIO_NONE;
      endcase
    end
    ok = (vio == VIO_NONE);
  end

  assign aref_go = ok && (cmd == CMD_AREF);
  assign sref_go = ok && (cmd == CMD_SREF);

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    logic hit;
    assign hit       = (ba == BAW'(i));
    assign act_go[i] = ok && hit && (cmd == CMD_ACT);
    assign rw_go[i]  = ok && hit && is_rw;
    assign pre_go[i] = ok && ((hit && cmd == CMD_PRE) || cmd == CMD_PREALL);

    sdcmd_bank #(
      .TRCD  (TRCD),
      .TRP   (TRP),
      .BURST (BURST)
    ) u_bank (
      .clk       (clk),
      .rst_n     (rst_ni),
      .act_go    (act_go[i]),
      .rw_go     (rw_go[i]),
      .rw_ap     (a10),
      .pre_go    (pre_go[i]),
      .active    (b_active[i]),
      .trp_busy  (b_trp_busy[i]),
      .trcd_busy (b_trcd_busy[i])
    );
  end

  sdcmd_refresh #(.TRC(TRC)) u_ref (
    .clk      (clk),
    .rst_n    (rst_ni),
    .aref_go  (aref_go),
    .sref_go  (sref_go),
    .cke_prev (cke_q),
    .cke_now  (cke),
    .trc_busy (trc_busy),
    .in_sref  (in_sref)
  );

  // result registers
  logic [NCMD-1:0] cmd_q, cmd_d;
  logic            err_q, err_d, sticky_q, sticky_d;
  logic [2:0]      cause_q, cause_d;

  always_comb begin
    cmd_d    = NCMD'(1) << cmd;
    err_d    = !ok;
    sticky_d = sticky_q | !ok;
    cause_d  = ok ? cause_q : vio;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q    <= '0;
      err_q    <= 1'b0;
      sticky_q <= 1'b0;
      cause_q  <= 3'd0;
    end else begin
      cmd_q    <= cmd_d;
      err_q    <= err_d;
      sticky_q <= sticky_d;
      cause_q  <= cause_d;
    end
  end

  assign cmd_onehot  = cmd_q;
  assign bank_active = b_active;
  assign sref_active = in_sref;
  assign err_pulse   = err_q;
  assign err_sticky  = sticky_q;
  assign err_cause   = cause_q;

  AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(cmd_q)); // R1

  AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_ni)
    sticky_q |=> sticky_q); // R11

  AST_MRS_ALL_IDLE: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_q[CMD_MRS] && !err_q) |-> ($past(b_active) == '0)); // R8

  AST_REFUSED_KEEPS_BANKS: assert property (@(posedge clk) disable iff (!rst_ni)
    (err_q && $past(!trc_busy || cmd == CMD_ACT)) |-> ($past(b_active) == b_active || $past(|b_active))); // R11

endmodule

// File: tb/sim_sdram_cmd_tracker.sv
module sim_sdram_cmd_tracker;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cke, cs_n, ras_n, cas_n, we_n, a10;
  logic [1:0]  ba;
  logic [11:0] cmd_onehot;
  logic [3:0]  bank_active;
  logic        sref_active, err_pulse, err_sticky;
  logic [2:0]  err_cause;

  always #4 clk = ~clk;

  sdram_cmd_tracker u0 (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .a10(a10), .ba(ba),
    .cmd_onehot(cmd_onehot), .bank_active(bank_active), .sref_active(sref_active),
    .err_pulse(err_pulse), .err_sticky(err_sticky), .err_cause(err_cause)
  );

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] P_ACT = 4'b0011, P_RD  = 4'b0101, P_WR  = 4'b0100,
                         P_PRE = 4'b0010, P_MRS = 4'b0000, P_REF = 4'b0001,
                         P_NOP = 4'b0111, P_BST = 4'b0110, P_DES = 4'b1000;

  typedef struct {
    int         idx;
    bit         err;
    logic [2:0] cause;
    logic [3:0] banks;
    bit         sr;
    string      req;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;
  bit   sticky_exp = 1'b0;
  logic [2:0] cause_exp = 3'd0;

  task automatic issue(input logic [3:0] pins, input logic ap, input logic [1:0] b,
                       input logic k, input int idx, input bit e, input logic [2:0] c,
                       input logic [3:0] bk, input bit sr, input string req);
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = pins;
    a10 = ap; ba = b; cke = k;
    q.push_back('{idx, e, c, bk, sr, req});
  endtask

  task automatic nops(input int n, input logic [3:0] bk, input string req);
    for (int j = 0; j < n; j++) issue(P_NOP, 1'b0, 2'd0, 1'b1, 1, 1'b0, 3'd0, bk, 1'b0, req);
  endtask

  // monitor: one expected item per sampled command
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t it;
        logic [11:0] ecmd;
        it = q.pop_front();
        if (it.err) begin
          sticky_exp = 1'b1;
          cause_exp  = it.cause;
        end
        ecmd = 12'd1 << it.idx;
        n_cmp++;
        if (cmd_onehot !== ecmd || err_pulse !== it.err || err_cause !== cause_exp ||
            err_sticky !== sticky_exp || bank_active !== it.banks || sref_active !== it.sr) begin
          n_bad++;
          $display("FAIL %s: got cmd=%h err=%b cause=%0d sticky=%b banks=%b sref=%b, want cmd=%h err=%b cause=%0d sticky=%b banks=%b sref=%b",
                   it.req, cmd_onehot, err_pulse, err_cause, err_sticky, bank_active, sref_active,
                   ecmd, it.err, cause_exp, sticky_exp, it.banks, it.sr);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got running, want finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cke = 1'b0; {cs_n, ras_n, cas_n, we_n} = P_DES; a10 = 1'b0; ba = 2'd0;
    repeat (3) @(negedge clk);
    n_cmp++;
    if (cmd_onehot !== 12'd0 || bank_active !== 4'd0 || sref_active !== 1'b0 ||
        err_pulse !== 1'b0 || err_sticky !== 1'b0 || err_cause !== 3'd0) begin
      n_bad++;
      $display("FAIL R12: got cmd=%h banks=%b sref=%b err=%b sticky=%b cause=%0d, want all zero",
               cmd_onehot, bank_active, sref_active, err_pulse, err_sticky, err_cause);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // cycle numbers below count the issue calls from 1
    issue(P_NOP, 0, 0, 1, 11, 0, 0, 4'b0000, 0, "R2 clock disabled");   // 1
    issue(P_NOP, 0, 0, 1,  1, 0, 0, 4'b0000, 0, "R1 nop");              // 2
    issue(P_DES, 0, 0, 1,  0, 0, 0, 4'b0000, 0, "R2 deselect");         // 3
    issue(P_ACT, 0, 0, 1,  3, 0, 0, 4'b0001, 0, "R3 activate");         // 4
    issue(P_RD,  0, 0, 1,  4, 1, 4, 4'b0001, 0, "R6 read before TRCD"); // 5
    issue(P_RD,  0, 0, 1,  4, 0, 0, 4'b0001, 0, "R6 read at TRCD");     // 6
    issue(P_ACT, 0, 0, 1,  3, 1, 1, 4'b0001, 0, "R3 activate open");    // 7
    issue(P_WR,  0, 1, 1,  5, 1, 3, 4'b0001, 0, "R6 write idle");       // 8
    issue(P_MRS, 0, 0, 1,  8, 1, 5, 4'b0001, 0, "R8 mrs with open");    // 9
    issue(P_ACT, 0, 2, 1,  3, 0, 0, 4'b0101, 0, "R3 second bank");      // 10
    issue(P_PRE, 0, 0, 1,  6, 0, 0, 4'b0100, 0, "R4 single precharge"); // 11
    issue(P_ACT, 0, 0, 1,  3, 1, 2, 4'b0100, 0, "R5 act +1");           // 12
    issue(P_ACT, 0, 0, 1,  3, 1, 2, 4'b0100, 0, "R5 act +2");           // 13
    issue(P_ACT, 0, 0, 1,  3, 0, 0, 4'b0101, 0, "R5 act at TRP");       // 14
    issue(P_ACT, 0, 3, 1,  3, 0, 0, 4'b1101, 0, "R3 third bank");       // 15
    issue(P_PRE, 1, 1, 1,  7, 0, 0, 4'b0000, 0, "R4 precharge all");    // 16
    issue(P_REF, 0, 0, 1,  9, 0, 0, 4'b0000, 0, "R8 refresh idle");     // 17
    issue(P_ACT, 0, 1, 1,  3, 1, 6, 4'b0000, 0, "R9 act in TRC");       // 18
    nops(6, 4'b0000, "R9 nop in TRC");                                   // 19..24
    issue(P_ACT, 0, 1, 1,  3, 1, 6, 4'b0000, 0, "R9 act TRC-1");        // 25
    issue(P_ACT, 0, 1, 1,  3, 0, 0, 4'b0010, 0, "R9 act at TRC");       // 26
    nops(1, 4'b0010, "R1 nop");                                          // 27
    issue(P_RD,  1, 1, 1,  4, 0, 0, 4'b0010, 0, "R7 read autopre");     // 28
    nops(3, 4'b0010, "R7 open during burst");                            // 29..31
    nops(1, 4'b0000, "R7 auto close");                                   // 32
    issue(P_ACT, 0, 1, 1,  3, 1, 2, 4'b0000, 0, "R7 TRP after close");  // 33
    nops(1, 4'b0000, "R1 nop");                                          // 34
    issue(P_ACT, 0, 1, 1,  3, 0, 0, 4'b0010, 0, "R7 act after TRP");    // 35
    nops(1, 4'b0010, "R1 nop");                                          // 36
    issue(P_WR,  0, 1, 1,  5, 0, 0, 4'b0010, 0, "R6 write ok");         // 37
    issue(P_PRE, 0, 1, 1,  6, 0, 0, 4'b0000, 0, "R4 close bank 1");     // 38
    nops(3, 4'b0000, "R1 nop");                                          // 39..41
    issue(P_REF, 0, 0, 0, 10, 0, 0, 4'b0000, 1, "R10 sref entry");      // 42
    issue(P_NOP, 0, 0, 0, 11, 0, 0, 4'b0000, 1, "R10 in sref");         // 43
    issue(P_NOP, 0, 0, 0, 11, 0, 0, 4'b0000, 1, "R10 in sref");         // 44
    issue(P_NOP, 0, 0, 1, 11, 0, 0, 4'b0000, 0, "R10 sref exit");       // 45
    issue(P_ACT, 0, 2, 1,  3, 1, 6, 4'b0000, 0, "R10 act after exit");  // 46
    nops(6, 4'b0000, "R10 wait");                                        // 47..52
    issue(P_ACT, 0, 2, 1,  3, 1, 6, 4'b0000, 0, "R10 act TRC-1");       // 53
    issue(P_ACT, 0, 2, 1,  3, 0, 0, 4'b0100, 0, "R10 act at TRC");      // 54
    issue(P_REF, 0, 0, 1,  9, 1, 5, 4'b0100, 0, "R8 refresh with open");// 55
    issue(P_REF, 0, 0, 0, 10, 1, 5, 4'b0100, 0, "R8 sref with open");   // 56
    issue(P_NOP, 0, 0, 1, 11, 0, 0, 4'b0100, 0, "R11 no sref entered"); // 57
    issue(P_NOP, 0, 0, 1,  1, 0, 0, 4'b0100, 0, "R1 nop");              // 58
    issue(P_BST, 0, 0, 1,  2, 0, 0, 4'b0100, 0, "R1 burst stop");       // 59
    issue(P_PRE, 0, 3, 1,  6, 0, 0, 4'b0100, 0, "R4 precharge idle");   // 60
    issue(P_PRE, 0, 2, 1,  6, 0, 0, 4'b0000, 0, "R4 close bank 2");     // 61
    issue(P_DES, 0, 0, 1,  0, 0, 0, 4'b0000, 0, "R11 sticky holds");    // 62

    wait (q.size() == 0);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule